// File: doc/BRIEF.md
# Floating-Point Data Class Tester

This block decides whether an IEEE-754 operand belongs to any of the classes picked by a 7-bit class-select mask. The classes are NaN, signed infinity, signed zero and signed denormal. The operand is a 128-bit word. It is read as four binary32 lanes, two binary64 lanes or one binary128 value, depending on a 2-bit format code. A third binary64 reading adds a single-precision test.

In scalar mode the block produces a 4-bit condition nibble. The nibble is meant to be copied unchanged into a condition-register field and into the class field of a status register. It carries the operand sign, the match result and, in the single-precision test, a flag that marks a binary64 value with no exact single-precision equivalent.

In vector mode the block tests every lane on its own and returns a mask with one field per lane. Each field is all ones when its lane matches and all zeros otherwise. All logic is combinational, and both outputs are registered, so a result appears one clock after its inputs.

Top module: `fp_class_tester`

## Requirements
- R1: A NaN, quiet or signalling (exponent all ones, fraction nonzero), matches exactly when mask bit 6 is set. Mask bit 0 is the least significant bit.
- R2: An infinity (exponent all ones, fraction zero) matches on mask bit 5 when positive and on mask bit 4 when negative.
- R3: A zero (exponent and fraction zero) matches on mask bit 3 when positive and on mask bit 2 when negative.
- R4: A denormal (exponent zero, fraction nonzero) matches on mask bit 1 when positive and on mask bit 0 when negative. A normal finite value never matches, whatever the mask. The classes are tested in the order NaN, infinity, zero, denormal.
- R5: In scalar mode (vec_mode=0) the nibble is {LT,GT,EQ,SO} from bit 3 down to bit 0. LT is the operand sign, GT is always 0, EQ is the match, and lane_mask is all zeros.
- R6: Format codes: 0 tests a binary32 value in bits 31:0 (the scalar case uses only this lane). 1 tests binary64 in bits 63:0. 2 tests binary128 in bits 127:0. 3 is the single-precision test of the binary64 value in bits 63:0. In scalar mode, bits outside the selected value have no effect.
- R7: In the single-precision test, a binary64 value whose biased exponent (bits 62:52) lies in 1 to 0x380 inclusive is classed as denormal and uses mask bit 1 or 0.
- R8: In the single-precision test, SO is 1 when rounding the value to single precision (nearest-even) and widening it back would not give the original bits. NaN, infinity and zero always count as representable. SO is 0 in every other format.
- R9: In vector mode (vec_mode=1) each lane's field in lane_mask is all ones on a match and all zeros otherwise. Lanes are tested independently, and the nibble is 0. Format 3 in vector mode behaves as format 1, with no forced denormal.
- R10: Both outputs are registered, so a result is visible one clock after its inputs. While rst_n is low, both outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vec_mode | input | 1 | 1 = per-lane vector test, 0 = scalar test |
| fmt | input | 2 | Format code (see R6) |
| class_mask | input | 7 | Class-select mask |
| operand | input | 128 | Operand word |
| cond_nib | output | 4 | Registered {LT,GT,EQ,SO} nibble |
| lane_mask | output | 128 | Registered per-lane match mask |

## Verification
The assertions check, on every cycle, these properties:
- The outputs of the mode that is not selected stay zero.
- Binary32 vector fields are uniform.
- LT follows the binary64 sign.
- SO stays low outside the single-precision test.
- A NaN cannot match while mask bit 6 is clear.
- Values in the tiny single-precision range match when both denormal bits are set.

Only the bench's sweeps can show the rest:
- The full sign-to-mask-bit mapping for every class, in all three widths.
- The independence of neighbouring lanes.
- The exact boundaries of the single-precision exponent range.
- The trailing-bit exactness test near 0x380, 0x381 and 0x47E.

// File: rtl/fpc_pkg.sv
package fpc_pkg;
  typedef enum logic [1:0] {
    FMT_S32 = 2'd0,
    FMT_D64 = 2'd1,
    FMT_Q128 = 2'd2,
    FMT_SPT = 2'd3
  } fpc_fmt_e;

  localparam int MASK_W = 7;
  localparam int NIB_W  = 4;

  // class-select mask bit positions
  localparam int MB_NAN   = 6;
  localparam int MB_INF_P = 5;
  localparam int MB_INF_N = 4;
  localparam int MB_ZER_P = 3;
  localparam int MB_ZER_N = 2;
  localparam int MB_DEN_P = 1;
  localparam int MB_DEN_N = 0;

  // condition nibble bit positions
  localparam int NB_LT = 3;
  localparam int NB_GT = 2;
  localparam int NB_EQ = 1;
  localparam int NB_SO = 0;
endpackage

// File: rtl/fpc_classify.sv
module fpc_classify
  import fpc_pkg::*;
#(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52,
  localparam int VAL_W = 1 + EXP_W + FRAC_W
) (
  input  logic [VAL_W-1:0]  val,
  input  logic [MASK_W-1:0] mask,
  input  logic              force_den,
  output logic              match,
  output logic              sign
);
  logic [EXP_W-1:0]  exp_f;
  logic [FRAC_W-1:0] frac_f;
  logic ex_max, ex_zero, fr_zero;
  logic is_nan, is_inf, is_zero, is_den;

  assign sign    = val[VAL_W-1];
  assign exp_f   = val[VAL_W-2 -: EXP_W];
  assign frac_f  = val[FRAC_W-1:0];
  assign ex_max  = &exp_f;
  assign ex_zero = ~|exp_f;
  assign fr_zero = ~|frac_f;

  // class flags in priority order
  assign is_nan  = ex_max & ~fr_zero;
  assign is_inf  = ex_max & fr_zero;
  assign is_zero = ex_zero & fr_zero;
  assign is_den  = ~ex_max & ~is_zero & ((ex_zero & ~fr_zero) | force_den);

  always_comb begin
    match = 1'b0;
    if (is_nan)       match = mask[MB_NAN];
    else if (is_inf)  match = sign ? mask[MB_INF_N] : mask[MB_INF_P];
    else if (is_zero) match = sign ? mask[MB_ZER_N] : mask[MB_ZER_P];
    else if (is_den)  match = sign ? mask[MB_DEN_N] : mask[MB_DEN_P];
  end
endmodule

// File: rtl/fpc_sp_fit.sv
module fpc_sp_fit #(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52,
  parameter int SP_EXP_MIN = 897,   // smallest biased binary64 exponent of a single normal
  parameter int SP_EXP_MAX = 1150,  // largest biased binary64 exponent of a single normal
  parameter int SP_FRAC_W  = 23,
  localparam int VAL_W = 1 + EXP_W + FRAC_W,
  localparam int SIG_W = FRAC_W + 1,
  localparam int SH_W  = $clog2(SIG_W + 1),
  localparam int DROP_N = FRAC_W - SP_FRAC_W,          // 29
  localparam int SUB_LO = SP_EXP_MIN - SP_FRAC_W,      // lowest exponent that may still fit
  localparam int SH_OFF = SP_EXP_MIN + DROP_N          // shift = SH_OFF - exp below normal range
) (
  input  logic [VAL_W-1:0] dval,
  output logic             fits,
  output logic             tiny
);
  logic [EXP_W-1:0]  e;
  logic [FRAC_W-1:0] f;
  logic [SIG_W-1:0]  sig, lowm;
  logic [SH_W-1:0]   sh;
  logic              in_rng;

  assign e   = dval[VAL_W-2 -: EXP_W];
  assign f   = dval[FRAC_W-1:0];
  assign sig = {1'b1, f};

  // nonzero exponent below the single normal range
  assign tiny = (e != '0) && (e < EXP_W'(SP_EXP_MIN));

  always_comb begin
    if (e >= EXP_W'(SP_EXP_MIN))      sh = SH_W'(DROP_N);
    else if (e >= EXP_W'(SUB_LO))     sh = SH_W'(EXP_W'(SH_OFF) - e);
    else                              sh = SH_W'(SIG_W);
    in_rng = (e != '0) && (e <= EXP_W'(SP_EXP_MAX)) && (sh < SH_W'(SIG_W));
    lowm   = (SIG_W'(1) << sh) - SIG_W'(1);
    fits   = (&e) | ((e == '0) & (f == '0)) | (in_rng & ~|(sig & lowm));
  end
endmodule

// File: rtl/fp_class_tester.sv
module fp_class_tester
  import fpc_pkg::*;
#(
  parameter int OPW = 128,
  localparam int L32 = OPW / 32,
  localparam int L64 = OPW / 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vec_mode,
  input  logic [1:0]        fmt,
  input  logic [MASK_W-1:0] class_mask,
  input  logic [OPW-1:0]    operand,
  output logic [NIB_W-1:0]  cond_nib,
  output logic [OPW-1:0]    lane_mask
);
  fpc_fmt_e fmt_e;
  logic [L32-1:0] m32, s32;
  logic [L64-1:0] m64, s64;
  logic m128, s128;
  logic sp_fits, sp_tiny, force_den0;
  logic [NIB_W-1:0] nib_d, nib_q;
  logic [OPW-1:0]   lanes_d, lanes_q;

  assign fmt_e = fpc_fmt_e'(fmt);
  assign force_den0 = ~vec_mode & (fmt_e == FMT_SPT) & sp_tiny;

  genvar k;
  generate
    for (k = 0; k < L32; k++) begin : g_s32
      fpc_classify #(.EXP_W(8), .FRAC_W(23)) u_cls (
        .val(operand[32*k +: 32]), .mask(class_mask), .force_den(1'b0),
        .match(m32[k]), .sign(s32[k]));
    end
    for (k = 0; k < L64; k++) begin : g_d64
      fpc_classify #(.EXP_W(11), .FRAC_W(52)) u_cls (
        .val(operand[64*k +: 64]), .mask(class_mask),
        .force_den((k == 0) ? force_den0 : 1'b0),
        .match(m64[k]), .sign(s64[k]));
    end
  endgenerate

  fpc_classify #(.EXP_W(15), .FRAC_W(112)) u_q128 (
    .val(operand[127:0]), .mask(class_mask), .force_den(1'b0),
    .match(m128), .sign(s128));

  fpc_sp_fit u_spfit (.dval(operand[63:0]), .fits(sp_fits), .tiny(sp_tiny));

  // next-state
  always_comb begin
    nib_d   = '0;
    lanes_d = '0;
    if (vec_mode) begin
      case (fmt_e)
        FMT_S32:  for (int i = 0; i < L32; i++) lanes_d[32*i +: 32] = {32{m32[i]}};
        FMT_Q128: lanes_d[127:0] = {128{m128}};
        default:  for (int i = 0; i < L64; i++) lanes_d[64*i +: 64] = {64{m64[i]}};
      endcase
    end else begin
      case (fmt_e)
        FMT_S32: begin
          nib_d[NB_LT] = s32[0];
          nib_d[NB_EQ] = m32[0];
        end
        FMT_D64: begin
          nib_d[NB_LT] = s64[0];
          nib_d[NB_EQ] = m64[0];
        end
        FMT_Q128: begin
          nib_d[NB_LT] = s128;
          nib_d[NB_EQ] = m128;
        end
        default: begin
          nib_d[NB_LT] = s64[0];
          nib_d[NB_EQ] = m64[0];
          nib_d[NB_SO] = ~sp_fits;
        end
      endcase
    end
  end

  // register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nib_q   <= '0;
      lanes_q <= '0;
    end else begin
      nib_q   <= nib_d;
      lanes_q <= lanes_d;
    end
  end

  assign cond_nib  = nib_q;
  assign lane_mask = lanes_q;

  // assertions
  p_lane_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(vec_mode)) |-> (lane_mask == '0));

  p_nib_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(vec_mode)) |-> (cond_nib == '0));

  p_sign_lt_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(vec_mode) && $past(fmt) == 2'd1)
      |-> (cond_nib[NB_LT] == $past(operand[63])));

  p_so_only_spt_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(fmt) != 2'd3) |-> !cond_nib[NB_SO]);

  p_nan_needs_bit_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(vec_mode) && $past(fmt) == 2'd1 &&
     $past(operand[62:52]) == 11'h7FF && $past(operand[51:0]) != '0 &&
     !$past(class_mask[MB_NAN])) |-> !cond_nib[NB_EQ]);

  p_sp_tiny_den_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(vec_mode) && $past(fmt) == 2'd3 &&
     $past(operand[62:52]) != '0 && $past(operand[62:52]) <= 11'h380 &&
     $past(class_mask[1:0]) == 2'b11) |-> cond_nib[NB_EQ]);

  generate
    for (k = 0; k < L32; k++) begin : g_uni
      p_lane_uniform_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(vec_mode) && $past(fmt) == 2'd0)
          |-> (lane_mask[32*k +: 32] == '0 || lane_mask[32*k +: 32] == '1));
    end
  endgenerate
endmodule

// File: tb/sim_fp_class_tester.sv
module sim_fp_class_tester;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vec_mode = 1'b0;
  logic [1:0] fmt = 2'd0;
  logic [6:0] class_mask = '0;
  logic [127:0] operand = '0;
  logic [3:0] cond_nib;
  logic [127:0] lane_mask;
  int errs = 0, checks = 0;
  bit done = 0;

  always #2 clk = ~clk;

  fp_class_tester u0 (.clk, .rst_n, .vec_mode, .fmt, .class_mask, .operand,
                      .cond_nib, .lane_mask);

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  endtask

  // class index per R1-R4 and R7; -1 = no class
  function automatic int cls_idx(logic [127:0] v, int ew, int fw, bit spt);
    logic [127:0] e, f, emax;
    bit s;
    s    = v[ew+fw];
    emax = (128'(1) << ew) - 1;
    e    = (v >> fw) & emax;
    f    = v & ((128'(1) << fw) - 1);
    if (e == emax && f != 0) return 6;
    if (e == emax) return s ? 4 : 5;
    if (e == 0 && f == 0) return s ? 2 : 3;
    if (e == 0 || (spt && e <= 128'h380)) return s ? 0 : 1;
    return -1;
  endfunction

  function automatic bit lane_hit(logic [127:0] v, int ew, int fw, logic [6:0] m, bit spt);
    int i;
    i = cls_idx(v, ew, fw, spt);
    return (i >= 0) && m[i];
  endfunction

  // exact single-precision equivalent exists (R8)
  function automatic bit sp_ok(logic [63:0] v);
    int e, t;
    logic [52:0] sig;
    e = int'(v[62:52]);
    if (e == 2047) return 1;
    if (e == 0) return v[51:0] == 0;
    if (e > 1150) return 0;
    sig = {1'b1, v[51:0]};
    t = 0;
    while (!sig[t]) t++;
    return (t >= 29) && (e - 1075 + t >= -149);
  endfunction

  function automatic logic [127:0] mkval(int ew, int fw, int cls, bit s);
    logic [127:0] e, f, emax;
    emax = (128'(1) << ew) - 1;
    case (cls)
      0: begin e = emax; f = 128'(1) << (fw - 1); end
      1: begin e = emax; f = 1; end
      2: begin e = emax; f = 0; end
      3: begin e = 0; f = 0; end
      4: begin e = 0; f = 3; end
      5: begin e = 1; f = 5; end
      default: begin e = (128'(1) << (ew - 1)) - 1; f = 0; end
    endcase
    return (128'(s) << (ew + fw)) | (e << fw) | f;
  endfunction

  task automatic expect_out(bit vm, logic [1:0] fm, logic [6:0] m, logic [127:0] op,
                            output logic [3:0] en, output logic [127:0] el);
    en = '0; el = '0;
    if (vm) begin
      case (fm)
        2'd0: for (int k = 0; k < 4; k++) el[32*k +: 32] = {32{lane_hit(op >> (32*k), 8, 23, m, 0)}};
        2'd2: el = {128{lane_hit(op, 15, 112, m, 0)}};
        default: for (int k = 0; k < 2; k++) el[64*k +: 64] = {64{lane_hit(op >> (64*k), 11, 52, m, 0)}};
      endcase
    end else begin
      case (fm)
        2'd0: en = {op[31], 1'b0, lane_hit(op & 128'hFFFF_FFFF, 8, 23, m, 0), 1'b0};
        2'd1: en = {op[63], 1'b0, lane_hit(op & {64'd0, {64{1'b1}}}, 11, 52, m, 0), 1'b0};
        2'd2: en = {op[127], 1'b0, lane_hit(op, 15, 112, m, 0), 1'b0};
        default: en = {op[63], 1'b0, lane_hit(op & {64'd0, {64{1'b1}}}, 11, 52, m, 1), !sp_ok(op[63:0])};
      endcase
    end
  endtask

  task automatic run(string req, bit vm, logic [1:0] fm, logic [6:0] m, logic [127:0] op);
    logic [3:0] en;
    logic [127:0] el;
    @(negedge clk);
    vec_mode = vm; fmt = fm; class_mask = m; operand = op;
    expect_out(vm, fm, m, op, en, el);
    @(negedge clk);
    checks++;
    if (cond_nib !== en || lane_mask !== el) begin
      errs++;
      $display("FAIL %s: vm=%0d fmt=%0d mask=%h op=%h nib=%h lanes=%h expected nib=%h lanes=%h",
               req, vm, fm, m, op, cond_nib, lane_mask, en, el);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog: run hung, actual=running expected=finished");
    summary();
  end

  initial begin
    logic [127:0] op;
    // R10: reset state, inputs active
    vec_mode = 1'b1; fmt = 2'd0; class_mask = 7'h7F; operand = '1;
    repeat (3) @(negedge clk);
    checks++;
    if (cond_nib !== 4'h0 || lane_mask !== '0) begin
      errs++;
      $display("FAIL R10: nib=%h lanes=%h expected nib=0 lanes=0", cond_nib, lane_mask);
    end
    rst_n = 1'b1;

    // R1-R6: scalar sweep, all classes and masks, upper bits junk
    for (int fm = 0; fm < 3; fm++)
      for (int c = 0; c < 7; c++)
        for (int s = 0; s < 2; s++)
          for (int m = 0; m < 128; m++) begin
            case (fm)
              0: op = {mkval(8, 23, (c + 2) % 7, 1)[95:0], mkval(8, 23, c, s[0])[31:0]};
              1: op = {mkval(11, 52, (c + 3) % 7, 0)[63:0], mkval(11, 52, c, s[0])[63:0]};
              default: op = mkval(15, 112, c, s[0]);
            endcase
            run(c < 2 ? "R1" : c == 2 ? "R2" : c == 3 ? "R3" : c == 4 ? "R4" : "R5",
                1'b0, 2'(fm), 7'(m), op);
          end

    // R9: vector sweep, mixed lane classes
    for (int fm = 0; fm < 4; fm++)
      for (int c = 0; c < 7; c++)
        for (int m = 0; m < 128; m += 3) begin
          op = '0;
          if (fm == 0) for (int k = 0; k < 4; k++)
            op[32*k +: 32] = mkval(8, 23, (c + k) % 7, 1'(k ^ c))[31:0];
          else if (fm == 2) op = mkval(15, 112, c, 1'(c));
          else for (int k = 0; k < 2; k++)
            op[64*k +: 64] = mkval(11, 52, (c + 3 * k) % 7, 1'(k ^ c))[63:0];
          run("R9", 1'b1, 2'(fm), 7'(m), op);
        end

    // R9: format 3 vector lanes with tiny exponent are normal
    run("R9", 1'b1, 2'd3, 7'h7F, {2{1'b0, 11'h380, 52'h0}});

    // R7, R8: single-precision test boundaries
    begin
      int ex[12] = '{0, 1, 'h369, 'h36A, 'h37F, 'h380, 'h381, 'h382, 'h3FF, 'h47E, 'h47F, 'h7FF};
      logic [51:0] fr[7] = '{52'h0, 52'h1 << 29, 52'h1 << 28, 52'h1, 52'hF_0000_0000_0000,
                             52'h1 << 45, 52'h1 << 46};
      logic [6:0] mk[3] = '{7'h7F, 7'h03, 7'h7C};
      foreach (ex[i]) foreach (fr[j]) foreach (mk[q])
        for (int s = 0; s < 2; s++)
          run((ex[i] > 0 && ex[i] <= 'h380) ? "R7" : "R8", 1'b0, 2'd3, mk[q],
              {64'hDEAD_BEEF_0123_4567, s[0], 11'(ex[i]), fr[j]});
    end

    // R10: back-to-back changes show one-cycle latency
    run("R10", 1'b0, 2'd1, 7'h08, 128'h0);
    run("R10", 1'b0, 2'd1, 7'h00, 128'h0);
    summary();
  end
endmodule